// File: doc/BRIEF.md
# Memory Fill Write Generator

This block walks a region of memory and writes a counting pattern into it through a memory port that has separate command and write-data channels. Before starting, the controlling logic presents a byte base address, a byte window end address and a byte length, then pulses `start`. The block converts these byte values into word terms and issues one write per data word. Each write begins with a command that carries the write flag and a word address. The data beat follows on the write-data channel.

The value stored in each word is that word's position in the run: 0 for the first word, then 1, then 2, and so on. Successive words go to successive word addresses, beginning at the word that holds the base byte. The offset from the base is folded into a window whose size in words is a power of two. A run longer than the window therefore wraps back to the base and overwrites the earlier words. When the last data beat has been accepted, the block raises `done` for one cycle and becomes idle.

Top module: `mem_fill_wr`

## Requirements
- R1: The number of writes in a run equals `length` shifted right by log2(DATA_W/8). Remainder bytes that do not fill a whole word are dropped.
- R2: The data of the k-th write in a run (k counted from 0) equals k, zero-extended to DATA_W.
- R3: The word address of the k-th write is B + (k AND (W-1)), taken modulo 2^WORD_ADDR_W. Here B is `base_addr` shifted right by log2(DATA_W/8), and W is the end word minus B. W must be a power of two.
- R4: Every write presents `cmd_valid` with `cmd_we`=1 first. `wr_valid` rises only in the cycle after a command handshake. The two valids are never high in the same cycle.
- R5: Once `cmd_valid` or `wr_valid` is raised, it stays high, with its address or data unchanged, until the matching ready is seen.
- R6: Every data beat carries all byte enables set.
- R7: `done` is high for exactly one cycle: the cycle after the final data handshake. `busy` is high from the cycle after an accepted start until that cycle, when it falls to 0.
- R8: A `start` pulse while `busy` is high is ignored. It changes neither the parameters nor the progress of the running fill.
- R9: A run whose word count is zero raises `done` in the cycle after `start` and produces no command or data traffic.
- R10: While reset is low and after its release, `busy`, `done`, `cmd_valid` and `wr_valid` are 0 until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a fill run when idle |
| base_addr | input | BYTE_ADDR_W | Byte address of the first word |
| end_addr | input | BYTE_ADDR_W | Byte address bounding the wrap window |
| length | input | LEN_W | Run length in bytes |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_valid | output | 1 | Command channel valid |
| cmd_ready | input | 1 | Command channel ready |
| cmd_we | output | 1 | Command write flag |
| cmd_addr | output | BYTE_ADDR_W-log2(DATA_W/8) | Word address of the write |
| wr_valid | output | 1 | Write-data channel valid |
| wr_ready | input | 1 | Write-data channel ready |
| wr_data | output | DATA_W | Write data |
| wr_be | output | DATA_W/8 | Byte enables |

## Verification
The hardest cases to reach from the ports are the exact alignment of `done` with the final data handshake when ready stalls randomly, and a run that wraps its window several times. The bench models the memory side with ready signals that stall at a random rate per run. It also uses directed runs whose length is a multiple of a small window, so that every address repeats. A second `start` with different parameters is injected in the middle of a stalled run, and that run's traffic must still match the original parameters.

// File: rtl/mfill_pkg.sv
package mfill_pkg;
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_CMD  = 2'd1,
        FS_DATA = 2'd2
    } fill_state_t;
endpackage

// File: rtl/mfill_geom.sv
module mfill_geom #(
    parameter int BYTE_ADDR_W = 32,
    parameter int LEN_W       = 32,
    parameter int SHIFT       = 2,
    localparam int WORD_ADDR_W = BYTE_ADDR_W - SHIFT,
    localparam int IDX_W       = LEN_W - SHIFT
) (
    input  logic [BYTE_ADDR_W-1:0] base_addr,
    input  logic [BYTE_ADDR_W-1:0] end_addr,
    input  logic [LEN_W-1:0]       length,
    output logic [WORD_ADDR_W-1:0] base_word,
    output logic [WORD_ADDR_W-1:0] win_mask,
    output logic [IDX_W-1:0]       word_count
);
    logic [WORD_ADDR_W-1:0] end_word;

    // Byte-to-word conversion drops the low address bits.
    always_comb begin
        base_word  = base_addr[BYTE_ADDR_W-1:SHIFT];
        end_word   = end_addr[BYTE_ADDR_W-1:SHIFT];
        win_mask   = end_word - base_word - WORD_ADDR_W'(1);
        word_count = length[LEN_W-1:SHIFT];
    end
endmodule

// File: rtl/mfill_addr.sv
module mfill_addr #(
    parameter int WORD_ADDR_W = 30,
    parameter int IDX_W       = 30
) (
    input  logic [WORD_ADDR_W-1:0] base_word,
    input  logic [WORD_ADDR_W-1:0] win_mask,
    input  logic [IDX_W-1:0]       idx,
    output logic [WORD_ADDR_W-1:0] word_addr
);
    logic [WORD_ADDR_W-1:0] idx_ext;

    always_comb begin
        idx_ext   = WORD_ADDR_W'(idx);
        word_addr = base_word + (idx_ext & win_mask);
    end
endmodule

// File: rtl/mfill_seq.sv
module mfill_seq
    import mfill_pkg::*;
#(
    parameter int WORD_ADDR_W = 30,
    parameter int IDX_W       = 30
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [WORD_ADDR_W-1:0] base_in,
    input  logic [WORD_ADDR_W-1:0] mask_in,
    input  logic [IDX_W-1:0]       count_in,
    input  logic                   cmd_ready,
    input  logic                   wr_ready,
    output fill_state_t            state,
    output logic [IDX_W-1:0]       idx,
    output logic [WORD_ADDR_W-1:0] base_word,
    output logic [WORD_ADDR_W-1:0] win_mask,
    output logic                   done
);
    typedef struct packed {
        fill_state_t            st;
        logic [IDX_W-1:0]       idx;
        logic [IDX_W-1:0]       count;
        logic [WORD_ADDR_W-1:0] base;
        logic [WORD_ADDR_W-1:0] mask;
        logic                   done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      last_beat;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        last_beat = (IDX_W'(r_q.idx + IDX_W'(1)) == r_q.count);
        unique case (r_q.st)
            FS_IDLE: begin
                if (start) begin
                    r_d.idx   = '0;
                    r_d.count = count_in;
                    r_d.base  = base_in;
                    r_d.mask  = mask_in;
                    if (count_in == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = FS_CMD;
                    end
                end
            end
            FS_CMD: begin
                if (cmd_ready) begin
                    r_d.st = FS_DATA;
                end
            end
            FS_DATA: begin
                if (wr_ready) begin
                    r_d.idx = IDX_W'(r_q.idx + IDX_W'(1));
                    if (last_beat) begin
                        r_d.st   = FS_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = FS_CMD;
                    end
                end
            end
            default: r_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: FS_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state     = r_q.st;
    assign idx       = r_q.idx;
    assign base_word = r_q.base;
    assign win_mask  = r_q.mask;
    assign done      = r_q.done;
endmodule

// File: rtl/mem_fill_wr.sv
module mem_fill_wr
    import mfill_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int BYTE_ADDR_W = 32,
    parameter int LEN_W       = 32,
    localparam int BE_W        = DATA_W / 8,
    localparam int SHIFT       = $clog2(BE_W),
    localparam int WORD_ADDR_W = BYTE_ADDR_W - SHIFT,
    localparam int IDX_W       = LEN_W - SHIFT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [BYTE_ADDR_W-1:0] base_addr,
    input  logic [BYTE_ADDR_W-1:0] end_addr,
    input  logic [LEN_W-1:0]       length,
    output logic                   busy,
    output logic                   done,
    output logic                   cmd_valid,
    input  logic                   cmd_ready,
    output logic                   cmd_we,
    output logic [WORD_ADDR_W-1:0] cmd_addr,
    output logic                   wr_valid,
    input  logic                   wr_ready,
    output logic [DATA_W-1:0]      wr_data,
    output logic [BE_W-1:0]        wr_be
);
    logic [WORD_ADDR_W-1:0] geo_base, geo_mask, run_base, run_mask;
    logic [IDX_W-1:0]       geo_count, run_idx;
    fill_state_t            st;

    mfill_geom #(
        .BYTE_ADDR_W(BYTE_ADDR_W), .LEN_W(LEN_W), .SHIFT(SHIFT)
    ) u_geom (
        .base_addr (base_addr),
        .end_addr  (end_addr),
        .length    (length),
        .base_word (geo_base),
        .win_mask  (geo_mask),
        .word_count(geo_count)
    );

    mfill_seq #(
        .WORD_ADDR_W(WORD_ADDR_W), .IDX_W(IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .base_in  (geo_base),
        .mask_in  (geo_mask),
        .count_in (geo_count),
        .cmd_ready(cmd_ready),
        .wr_ready (wr_ready),
        .state    (st),
        .idx      (run_idx),
        .base_word(run_base),
        .win_mask (run_mask),
        .done     (done)
    );

    mfill_addr #(
        .WORD_ADDR_W(WORD_ADDR_W), .IDX_W(IDX_W)
    ) u_addr (
        .base_word(run_base),
        .win_mask (run_mask),
        .idx      (run_idx),
        .word_addr(cmd_addr)
    );

    always_comb begin
        busy      = (st != FS_IDLE);
        cmd_valid = (st == FS_CMD);
        cmd_we    = 1'b1;
        wr_valid  = (st == FS_DATA);
        wr_data   = DATA_W'(run_idx);
        wr_be     = '1;
    end
endmodule

// File: rtl/mem_fill_wr_chk.sv
module mem_fill_wr_chk #(
    parameter int DATA_W      = 32,
    parameter int WORD_ADDR_W = 30,
    localparam int BE_W       = DATA_W / 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   busy,
    input logic                   done,
    input logic                   cmd_valid,
    input logic                   cmd_ready,
    input logic                   cmd_we,
    input logic [WORD_ADDR_W-1:0] cmd_addr,
    input logic                   wr_valid,
    input logic                   wr_ready,
    input logic [DATA_W-1:0]      wr_data,
    input logic [BE_W-1:0]        wr_be
);
    assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr));

    assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_data));

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && wr_valid));

    assert_cmd_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_we);

    assert_data_after_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(cmd_valid && cmd_ready));

    assert_full_be_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_be == {BE_W{1'b1}}));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind mem_fill_wr mem_fill_wr_chk #(
    .DATA_W(DATA_W), .WORD_ADDR_W(WORD_ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_we   (cmd_we),
    .cmd_addr (cmd_addr),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_data  (wr_data),
    .wr_be    (wr_be)
);

// File: tb/mem_fill_wr_bench.sv
module mem_fill_wr_bench;
    localparam int DW = 32;
    localparam int AW = 32;
    localparam int LW = 32;
    localparam int WAW = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW-1:0] end_addr = '0;
    logic [LW-1:0] length = '0;
    logic          busy, done, cmd_valid, cmd_we, wr_valid;
    logic          cmd_ready = 1'b0;
    logic          wr_ready = 1'b0;
    logic [WAW-1:0] cmd_addr;
    logic [DW-1:0] wr_data;
    logic [3:0]    wr_be;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int ready_pct = 100;
    int hs_count = 0;
    int last_hs_cyc = 0;
    int cmd_count = 0;
    logic [WAW-1:0] pend_addr = '0;
    logic [31:0] e_base = 0, e_end = 0;

    mem_fill_wr #(.DATA_W(DW), .BYTE_ADDR_W(AW), .LEN_W(LW)) u_mem_fill_wr (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .end_addr(end_addr), .length(length), .busy(busy), .done(done),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_we(cmd_we),
        .cmd_addr(cmd_addr), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .wr_be(wr_be)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [WAW-1:0] exp_addr(input logic [31:0] b, input logic [31:0] e, input int k);
        logic [31:0] bw, ew, m;
        bw = b >> 2;
        ew = e >> 2;
        m  = ew - bw - 1;
        return WAW'(bw + (32'(k) & m));
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory-side model: choose ready at falling edges; a handshake is
    // recorded when valid is already high and ready is being raised.
    initial begin
        forever begin
            @(negedge clk);
            cmd_ready = 1'b0;
            wr_ready  = 1'b0;
            if (cmd_valid && (($urandom % 100) < ready_pct)) begin
                cmd_ready = 1'b1;
                pend_addr = cmd_addr;
                cmd_count++;
            end
            if (wr_valid && (($urandom % 100) < ready_pct)) begin
                wr_ready = 1'b1;
                check("R2 data", 64'(wr_data), 64'(hs_count));
                check("R3 addr", 64'(pend_addr), 64'(exp_addr(e_base, e_end, hs_count)));
                check("R6 be", 64'(wr_be), 64'hF);
                hs_count++;
                last_hs_cyc = cyc;
            end
        end
    end

    task automatic run(input logic [31:0] b, input logic [31:0] e, input logic [31:0] len,
                       input int pct, input bit inject);
        int start_cyc, words, waited;
        e_base = b; e_end = e; ready_pct = pct;
        hs_count = 0; cmd_count = 0;
        words = int'(len >> 2);
        @(negedge clk);
        base_addr = b; end_addr = e; length = len; start = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        if (words > 0) check("R7 busy after start", 64'(busy), 64'd1);
        if (inject) begin
            repeat (3) @(negedge clk);
            base_addr = 32'h400; end_addr = 32'h404; length = 32'd4; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        check("R7 done seen", 64'(done), 64'd1);
        check("R1 write count", 64'(hs_count), 64'(words));
        check("R4 one cmd per write", 64'(cmd_count), 64'(words));
        if (words == 0) check("R9 done timing", 64'(cyc), 64'(start_cyc + 1));
        else check("R7 done timing", 64'(cyc), 64'(last_hs_cyc + 1));
        check("R7 busy low at done", 64'(busy), 64'd0);
        @(negedge clk);
        check("R7 done single pulse", 64'(done), 64'd0);
        if (inject) check("R8 no extra traffic", 64'(hs_count), 64'(words));
    endtask

    initial begin
        void'($urandom(32'd7));
        repeat (2) @(negedge clk);
        check("R10 busy in reset", 64'(busy), 64'd0);
        check("R10 cmd_valid in reset", 64'(cmd_valid), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 idle busy", 64'(busy), 64'd0);
        check("R10 idle done", 64'(done), 64'd0);
        check("R10 idle wr_valid", 64'(wr_valid), 64'd0);
        run(32'h10, 32'h30, 32'd20, 100, 0);   // R1 R2 R3 basic, 5 words
        run(32'h10, 32'h30, 32'd64, 60, 0);    // R3 wraps window of 8 twice
        run(32'h24, 32'h28, 32'd12, 50, 0);    // R3 window of one word
        run(32'h08, 32'h48, 32'd23, 100, 0);   // R1 remainder bytes dropped
        run(32'h10, 32'h30, 32'd0, 100, 0);    // R9 zero length
        run(32'h10, 32'h30, 32'd3, 100, 0);    // R9 sub-word length
        run(32'h20, 32'h40, 32'd40, 30, 1);    // R8 start ignored while busy
        for (int i = 0; i < 25; i++) begin
            logic [31:0] bb, ee, ll;
            int sz;
            bb = 32'(($urandom % 64) * 4);
            sz = 1 << ($urandom % 5);
            ee = bb + 32'(sz * 4);
            ll = 32'($urandom % 80);
            run(bb, ee, ll, 20 + ($urandom % 81), 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule